// File: doc/BRIEF.md
# NAND Page-Program Responder

This block is a synthesizable behavioural model of the device end of a NAND page-program interface. A controller under test drives it through single-cycle strobes that mark each byte on an 8-bit bus as a command, an address or a data byte. The model decodes these bus cycles, captures a column and a page address, and fills a page-wide data register through a column pointer. When the controller confirms, the model holds its ready line low for a fixed number of clock cycles. It then merges the loaded data into a small internal page array and records pass or fail in a status byte.

The page size and page count are reduced and set by parameters. The model applies the checks a controller must cope with. Programming can only clear bits. A page accepts only a limited number of partial programs before it needs an erase. A confirm with no data loaded is ignored. While the device is busy, only the status and reset commands are accepted. An erase strobe clears the partial-program count of one page. An observation port shows any byte of the array, so a test can check what was programmed.

Top module: `nand_prog_resp`

## Requirements
- R1: Command 80h followed by five address cycles opens a load. The low COL_W bits of the first address cycle set the column and the low PAGE_W bits of the third set the page. The other address cycles are ignored. Each data byte is stored at the column, and the column then increments, wrapping at the page end.
- R2: A load starts with every data-register byte at FFh. Bytes not loaded during the load leave the page array unchanged.
- R3: Command 85h followed by two address cycles moves the column to the low COL_W bits of the first of them. Data already loaded is kept. 85h is ignored outside a load.
- R4: Command 10h issued when no data byte has been loaded since the last 80h is ignored. Ready stays high and nothing is programmed.
- R5: An accepted 10h drives ready low on the next cycle. Ready stays low for exactly PROG_CYCLES cycles and then returns high.
- R6: At the end of the program phase, each byte of the addressed page becomes the bitwise AND of its old value and the data-register byte.
- R7: While ready is low, every command other than 70h and FFh is ignored, and so are address and data bytes.
- R8: A page accepts at most MAX_PARTIAL programs. A further program attempt sets the fail bit and leaves the page unchanged. An erase strobe clears the count of the page it names.
- R9: Status reads as {bit7=1, bit6=ready, bits5..1=0, bit0=fail}, so C0h means ready and pass, 80h means busy and C1h means ready and fail. After 70h, each read strobe returns status until 80h, 85h, an accepted 10h or FFh is written. Otherwise bus_out reads FFh.
- R10: Command FFh at any time aborts a load or a program phase without writing the array. It drives ready high on the next cycle, clears the fail bit and leaves status mode.
- R11: The pass/fail check flags only bits that should have become 0. Loading a 1 over a bit that is already 0 leaves the bit at 0 and reports pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_stb | input | 1 | bus_in carries a command byte this cycle |
| adr_stb | input | 1 | bus_in carries an address byte this cycle |
| din_stb | input | 1 | bus_in carries a data byte this cycle |
| rd_stb | input | 1 | Read cycle; bus_out is valid |
| bus_in | input | 8 | Byte from the controller |
| bus_out | output | 8 | Status byte in status mode during a read, else FFh |
| ready | output | 1 | High when idle, low during the program phase |
| erase_stb | input | 1 | Erase hook: clears the partial-program count of erase_page |
| erase_page | input | PAGE_W | Page whose count is cleared |
| peek_page | input | PAGE_W | Array observation page |
| peek_col | input | COL_W | Array observation column |
| peek_data | output | 8 | Array byte at peek_page/peek_col |

## Verification
The assertions check several rules on every cycle. Ready falls only after a confirm. A rise of ready that is not caused by a reset comes after exactly PROG_CYCLES low cycles. A bare confirm, or a command other than reset during busy, keeps ready where it was. Reset and status commands drive the ready and status outputs as required, and no page count exceeds the limit. The bench scenarios show the effects that land in the array: column and page capture, pointer increment, random-input relocation, the AND merge, the fail on the fifth program with the page left untouched, and the erase hook restoring programming. They also show that a load or program aborted by reset leaves the array unchanged.

// File: rtl/npr_pkg.sv
package npr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_LOAD,
        ST_CADDR,
        ST_BUSY
    } npr_state_e;

    localparam logic [7:0] CMD_LOAD   = 8'h80;
    localparam logic [7:0] CMD_RAND   = 8'h85;
    localparam logic [7:0] CMD_CONF   = 8'h10;
    localparam logic [7:0] CMD_STATUS = 8'h70;
    localparam logic [7:0] CMD_RESET  = 8'hFF;
endpackage

// File: rtl/npr_busy_timer.sv
module npr_busy_timer #(
    parameter int PROG_CYCLES = 16,
    localparam int TMR_W = $clog2(PROG_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic abort,
    output logic busy,
    output logic done
);
    logic [TMR_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (abort)
            cnt_d = '0;
        else if (start)
            cnt_d = TMR_W'(PROG_CYCLES);
        else if (cnt_q != '0)
            cnt_d = cnt_q - TMR_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == TMR_W'(1));
endmodule

// File: rtl/npr_page_array.sv
module npr_page_array #(
    parameter int COL_W       = 3,
    parameter int PAGE_W      = 2,
    parameter int CNT_W       = 3,
    localparam int PAGE_BYTES = 1 << COL_W,
    localparam int PAGES      = 1 << PAGE_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [PAGE_W-1:0]            wr_page,
    input  logic [PAGE_BYTES-1:0][7:0]   wr_data,
    input  logic                         erase_en,
    input  logic [PAGE_W-1:0]            erase_page,
    input  logic [PAGE_W-1:0]            cnt_page,
    output logic [CNT_W-1:0]             cnt_out,
    input  logic [PAGE_W-1:0]            peek_page,
    input  logic [COL_W-1:0]             peek_col,
    output logic [7:0]                   peek_data
);
    logic [PAGE_BYTES-1:0][7:0] page_data [PAGES];
    logic [CNT_W-1:0]           page_cnt  [PAGES];

    for (genvar p = 0; p < PAGES; p++) begin : g_page
        logic [PAGE_BYTES-1:0][7:0] data_d, data_q;
        logic [CNT_W-1:0]           cnt_d, cnt_q;

        always_comb begin
            data_d = data_q;
            cnt_d  = cnt_q;
            if (wr_en && wr_page == PAGE_W'(p)) begin
                data_d = data_q & wr_data;
                cnt_d  = cnt_q + CNT_W'(1);
            end
            if (erase_en && erase_page == PAGE_W'(p))
                cnt_d = '0;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                data_q <= '1;
                cnt_q  <= '0;
            end else begin
                data_q <= data_d;
                cnt_q  <= cnt_d;
            end
        end

        assign page_data[p] = data_q;
        assign page_cnt[p]  = cnt_q;
    end

    assign cnt_out   = page_cnt[cnt_page];
    assign peek_data = page_data[peek_page][peek_col];
endmodule

// File: rtl/nand_prog_resp.sv
module nand_prog_resp #(
    parameter int COL_W       = 3,
    parameter int PAGE_W      = 2,
    parameter int PROG_CYCLES = 16,
    parameter int MAX_PARTIAL = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_stb,
    input  logic              adr_stb,
    input  logic              din_stb,
    input  logic              rd_stb,
    input  logic [7:0]        bus_in,
    output logic [7:0]        bus_out,
    output logic              ready,
    input  logic              erase_stb,
    input  logic [PAGE_W-1:0] erase_page,
    input  logic [PAGE_W-1:0] peek_page,
    input  logic [COL_W-1:0]  peek_col,
    output logic [7:0]        peek_data
);
    import npr_pkg::*;

    localparam int PAGE_BYTES = 1 << COL_W;
    localparam int CNT_W      = $clog2(MAX_PARTIAL + 1);

    typedef struct packed {
        npr_state_e                 st;
        logic [2:0]                 aidx;
        logic [COL_W-1:0]           col;
        logic [PAGE_W-1:0]          page;
        logic [PAGE_BYTES-1:0][7:0] dreg;
        logic                       loaded;
        logic                       stat;
        logic                       fail;
    } regs_t;

    regs_t            r_d, r_q;
    logic             tmr_start, tmr_abort, tmr_busy, tmr_done;
    logic             prog_we;
    logic [CNT_W-1:0] part_cnt;
    logic             limit_hit;

    assign limit_hit = (part_cnt >= CNT_W'(MAX_PARTIAL));

    always_comb begin
        r_d       = r_q;
        tmr_start = 1'b0;
        tmr_abort = 1'b0;
        prog_we   = 1'b0;
        if (cmd_stb) begin
            if (bus_in == CMD_RESET) begin
                r_d.st     = ST_IDLE;
                r_d.dreg   = '1;
                r_d.loaded = 1'b0;
                r_d.stat   = 1'b0;
                r_d.fail   = 1'b0;
                tmr_abort  = 1'b1;
            end else if (bus_in == CMD_STATUS) begin
                r_d.stat = 1'b1;
            end else if (r_q.st != ST_BUSY) begin
                if (bus_in == CMD_LOAD) begin
                    r_d.st     = ST_ADDR;
                    r_d.aidx   = '0;
                    r_d.dreg   = '1;
                    r_d.loaded = 1'b0;
                    r_d.stat   = 1'b0;
                end else if (bus_in == CMD_RAND && r_q.st == ST_LOAD) begin
                    r_d.st   = ST_CADDR;
                    r_d.aidx = '0;
                    r_d.stat = 1'b0;
                end else if (bus_in == CMD_CONF && r_q.st == ST_LOAD && r_q.loaded) begin
                    r_d.st    = ST_BUSY;
                    r_d.stat  = 1'b0;
                    tmr_start = 1'b1;
                end
            end
        end else if (adr_stb && r_q.st == ST_ADDR) begin
            if (r_q.aidx == 3'd0) r_d.col  = bus_in[COL_W-1:0];
            if (r_q.aidx == 3'd2) r_d.page = bus_in[PAGE_W-1:0];
            r_d.aidx = r_q.aidx + 3'd1;
            if (r_q.aidx == 3'd4) r_d.st = ST_LOAD;
        end else if (adr_stb && r_q.st == ST_CADDR) begin
            if (r_q.aidx == 3'd0) r_d.col = bus_in[COL_W-1:0];
            r_d.aidx = r_q.aidx + 3'd1;
            if (r_q.aidx == 3'd1) r_d.st = ST_LOAD;
        end else if (din_stb && r_q.st == ST_LOAD) begin
            r_d.dreg[r_q.col] = bus_in;
            r_d.col           = r_q.col + COL_W'(1);
            r_d.loaded        = 1'b1;
        end

        if (r_q.st == ST_BUSY && tmr_done && !tmr_abort) begin
            r_d.st     = ST_IDLE;
            r_d.loaded = 1'b0;
            r_d.fail   = limit_hit;
            prog_we    = !limit_hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.dreg <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    npr_busy_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .abort (tmr_abort),
        .busy  (tmr_busy),
        .done  (tmr_done)
    );

    npr_page_array #(.COL_W(COL_W), .PAGE_W(PAGE_W), .CNT_W(CNT_W)) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (prog_we),
        .wr_page    (r_q.page),
        .wr_data    (r_q.dreg),
        .erase_en   (erase_stb),
        .erase_page (erase_page),
        .cnt_page   (r_q.page),
        .cnt_out    (part_cnt),
        .peek_page  (peek_page),
        .peek_col   (peek_col),
        .peek_data  (peek_data)
    );

    assign ready   = !tmr_busy;
    assign bus_out = (rd_stb && r_q.stat) ? {1'b1, ready, 5'b0, r_q.fail} : 8'hFF;
endmodule

// File: rtl/npr_chk.sv
module npr_chk #(
    parameter int PROG_CYCLES = 16,
    parameter int MAX_PARTIAL = 4,
    parameter int CNT_W       = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_stb,
    input logic             rd_stb,
    input logic [7:0]       bus_in,
    input logic [7:0]       bus_out,
    input logic             ready,
    input logic             loaded,
    input logic [CNT_W-1:0] part_cnt
);
    localparam int LW = $clog2(PROG_CYCLES + 2);
    logic [LW-1:0] low_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      low_cnt_q <= '0;
        else if (ready)  low_cnt_q <= '0;
        else             low_cnt_q <= low_cnt_q + LW'(1);
    end

    // R4
    a_r4_bare_confirm: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && bus_in == 8'h10 && ready && !loaded) |=> ready);

    // R5
    a_r5_busy_starts_on_confirm: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |-> $past(cmd_stb && bus_in == 8'h10));

    // R5
    a_r5_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ready) && !$past(cmd_stb && bus_in == 8'hFF)) |-> (low_cnt_q == LW'(PROG_CYCLES)));

    // R7
    a_r7_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && low_cnt_q < LW'(PROG_CYCLES - 1) && cmd_stb && bus_in != 8'hFF) |=> !ready);

    // R8
    a_r8_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        part_cnt <= CNT_W'(MAX_PARTIAL));

    // R9
    a_r9_status_read: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && bus_in == 8'h70) |=> (rd_stb |-> (bus_out[7] && bus_out[6] == ready)));

    // R10
    a_r10_reset_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && bus_in == 8'hFF) |=> (ready && bus_out == 8'hFF));
endmodule

bind nand_prog_resp npr_chk #(
    .PROG_CYCLES (PROG_CYCLES),
    .MAX_PARTIAL (MAX_PARTIAL),
    .CNT_W       (CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_stb  (cmd_stb),
    .rd_stb   (rd_stb),
    .bus_in   (bus_in),
    .bus_out  (bus_out),
    .ready    (ready),
    .loaded   (r_q.loaded),
    .part_cnt (part_cnt)
);

// File: tb/nand_prog_resp_tb.sv
module nand_prog_resp_tb;
    localparam int COL_W = 3;
    localparam int PAGE_W = 2;
    localparam int PROG_CYCLES = 16;
    localparam int MAX_PARTIAL = 4;

    localparam int K_CMD = 0;
    localparam int K_ADR = 1;
    localparam int K_DIN = 2;
    localparam int K_RD  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_stb = 1'b0, adr_stb = 1'b0, din_stb = 1'b0, rd_stb = 1'b0;
    logic [7:0] bus_in = 8'h00;
    logic [7:0] bus_out;
    logic ready;
    logic erase_stb = 1'b0;
    logic [PAGE_W-1:0] erase_page = '0;
    logic [PAGE_W-1:0] peek_page = '0;
    logic [COL_W-1:0] peek_col = '0;
    logic [7:0] peek_data;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    int exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    nand_prog_resp #(
        .COL_W(COL_W), .PAGE_W(PAGE_W),
        .PROG_CYCLES(PROG_CYCLES), .MAX_PARTIAL(MAX_PARTIAL)
    ) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_stb(cmd_stb), .adr_stb(adr_stb), .din_stb(din_stb), .rd_stb(rd_stb),
        .bus_in(bus_in), .bus_out(bus_out), .ready(ready),
        .erase_stb(erase_stb), .erase_page(erase_page),
        .peek_page(peek_page), .peek_col(peek_col), .peek_data(peek_data)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor: every read strobe pops one expected status byte
    always @(negedge clk) begin
        if (rd_stb) begin
            if (exp_q.size() == 0) begin
                checks++;
                failures++;
                $display("FAIL R9: unexpected read actual=%0h expected=none", bus_out);
            end else begin
                chk(tag_q.pop_front(), int'(bus_out), exp_q.pop_front());
            end
        end
    end

    task automatic op(input int kind, input logic [7:0] v);
        @(posedge clk); #1;
        cmd_stb = (kind == K_CMD);
        adr_stb = (kind == K_ADR);
        din_stb = (kind == K_DIN);
        rd_stb  = (kind == K_RD);
        bus_in  = v;
    endtask

    task automatic idle();
        @(posedge clk); #1;
        cmd_stb = 0; adr_stb = 0; din_stb = 0; rd_stb = 0;
    endtask

    task automatic rd_expect(input int exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        op(K_RD, 8'h00);
    endtask

    task automatic open_load(input int page, input int col);
        op(K_CMD, 8'h80);
        op(K_ADR, 8'(col));
        op(K_ADR, 8'h00);
        op(K_ADR, 8'(page));
        op(K_ADR, 8'h00);
        op(K_ADR, 8'h00);
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        forever begin
            @(negedge clk);
            if (ready) break;
            n++;
        end
    endtask

    task automatic peek(input int page, input int col, input int exp, input string tag);
        peek_page = PAGE_W'(page);
        peek_col = COL_W'(col);
        #1;
        chk(tag, int'(peek_data), exp);
    endtask

    task automatic prog1(input int page, input int col, input logic [7:0] d, input int exp_stat, input string tag);
        int n;
        open_load(page, col);
        op(K_DIN, d);
        op(K_CMD, 8'h10);
        idle();
        wait_ready(n);
        op(K_CMD, 8'h70);
        rd_expect(exp_stat, tag);
        idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk("R5 reset ready", int'(ready), 1);
        chk("R9 reset bus_out", int'(bus_out), 8'hFF);
        peek(0, 0, 8'hFF, "R2 reset array");

        // R4: bare confirm
        op(K_CMD, 8'h10);
        idle();
        @(negedge clk);
        chk("R4 bare confirm ready", int'(ready), 1);
        op(K_CMD, 8'h80);
        op(K_CMD, 8'h10);
        idle();
        @(negedge clk);
        chk("R4 confirm after empty load", int'(ready), 1);
        op(K_CMD, 8'h70);
        rd_expect(8'hC0, "R9 status idle pass");
        idle();

        // R1/R5/R6: program page 1 columns 2,3
        open_load(1, 2);
        op(K_DIN, 8'hA5);
        op(K_DIN, 8'h3C);
        op(K_CMD, 8'h10);
        idle();
        wait_ready(n);
        chk("R5 busy length", n, PROG_CYCLES);
        rd_expect(8'hFF, "R9 no status mode after confirm");
        op(K_CMD, 8'h70);
        rd_expect(8'hC0, "R9 status after program");
        rd_expect(8'hC0, "R9 status persists");
        idle();
        peek(1, 2, 8'hA5, "R1 col capture");
        peek(1, 3, 8'h3C, "R1 col increment");
        peek(1, 0, 8'hFF, "R2 unloaded byte");
        peek(0, 2, 8'hFF, "R1 page capture");

        // R3: random data input, plus column wrap
        open_load(2, 7);
        op(K_DIN, 8'h99);
        op(K_DIN, 8'h11);
        op(K_CMD, 8'h85);
        op(K_ADR, 8'h05);
        op(K_ADR, 8'h00);
        op(K_DIN, 8'h22);
        op(K_CMD, 8'h10);
        idle();
        wait_ready(n);
        peek(2, 7, 8'h99, "R1 col7");
        peek(2, 0, 8'h11, "R1 column wrap");
        peek(2, 5, 8'h22, "R3 moved column");
        peek(2, 1, 8'hFF, "R3 unwritten");

        // R7: commands ignored while busy
        open_load(0, 4);
        op(K_DIN, 8'h5A);
        op(K_CMD, 8'h10);
        op(K_CMD, 8'h80);
        op(K_ADR, 8'h00);
        op(K_DIN, 8'h00);
        op(K_CMD, 8'h70);
        rd_expect(8'h80, "R9 busy status");
        idle();
        @(negedge clk);
        chk("R7 still busy", int'(ready), 0);
        wait_ready(n);
        rd_expect(8'hC0, "R9 status after busy");
        idle();
        peek(0, 4, 8'h5A, "R7 load kept");
        peek(0, 0, 8'hFF, "R7 data ignored");

        // R6/R11: AND merge on page 1 (programs 2 and 3)
        prog1(1, 2, 8'h0F, 8'hC0, "R6 merge status");
        peek(1, 2, 8'h05, "R6 AND merge");
        prog1(1, 3, 8'hC3, 8'hC0, "R11 one over zero passes");
        peek(1, 3, 8'h00, "R11 bits stay 0");

        // R8: fourth passes, fifth fails
        prog1(1, 7, 8'h7E, 8'hC0, "R8 fourth program");
        peek(1, 7, 8'h7E, "R8 fourth written");
        prog1(1, 6, 8'h00, 8'hC1, "R8 fifth fails");
        peek(1, 6, 8'hFF, "R8 page unchanged");

        // R10: reset clears fail
        op(K_CMD, 8'hFF);
        op(K_CMD, 8'h70);
        rd_expect(8'hC0, "R10 fail cleared");
        idle();

        // R8: erase hook restores programming
        @(posedge clk); #1;
        erase_stb = 1'b1; erase_page = 2'd1;
        @(posedge clk); #1;
        erase_stb = 1'b0;
        prog1(1, 6, 8'h00, 8'hC0, "R8 after erase");
        peek(1, 6, 8'h00, "R8 written after erase");

        // R10: reset aborts load
        open_load(3, 0);
        op(K_DIN, 8'h00);
        op(K_CMD, 8'hFF);
        op(K_CMD, 8'h10);
        idle();
        @(negedge clk);
        chk("R10 confirm after abort ignored", int'(ready), 1);
        peek(3, 0, 8'hFF, "R10 aborted load");

        // R10: reset aborts program phase
        open_load(3, 1);
        op(K_DIN, 8'h00);
        op(K_CMD, 8'h10);
        idle();
        repeat (3) @(posedge clk);
        #1;
        op(K_CMD, 8'hFF);
        idle();
        @(negedge clk);
        chk("R10 ready after abort", int'(ready), 1);
        repeat (PROG_CYCLES + 2) @(posedge clk);
        #1;
        peek(3, 1, 8'hFF, "R10 aborted program");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule